// File: doc/BRIEF.md
# Synchronous Burst ROM Read Controller

This block sits between a host request port and an external clocked synchronous burst ROM. The host presents one request at a time: address, direction, access size and write data. The block then runs the external cycle, driving the chip select, read strobe, write strobe, a one-cycle start strobe and the beat address, and sampling the ROM data bus.

Every read is a full burst of 16 bytes. That is 8 beats on a 16-bit bus or 4 beats on a 32-bit bus, and it runs to the end even when the host needs only one or two beats. A programmable wait count is inserted before the first beat, and the device's wait input can stretch that count. A separate, shorter wait count is inserted before each later beat, and the device's wait input is ignored there. Writes use one plain access with no burst.

The request side uses a valid/ready handshake. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and the host must hold the request fields steady until then. `req_ready` is low for the whole external cycle. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse, and the host must capture `rsp_rdata` and `rsp_err` on that cycle. Bus width and both wait counts are captured when a request is accepted.

Top module: `brom_ctrl`

## Requirements
- R1: An accepted supported request is followed by exactly one setup cycle. In that cycle `rom_cs_n` is low. For reads, `rom_addr` equals the request address with its low 4 bits cleared (the 16-byte block base).
- R2: The number of wait cycles between the setup cycle and the first data beat equals `cfg_first_wait` (0 to 15). While `rom_wait` is high at or after the point where that count runs out, the first beat is delayed one cycle per cycle of `rom_wait`.
- R3: Between consecutive read beats there are exactly `cfg_beat_wait` (0 to 3) wait cycles, and `rom_wait` has no effect on them.
- R4: `rom_bs_n` is low only in the setup cycle, for exactly one cycle per transfer.
- R5: `cfg_width` code 1 selects a 16-bit bus and 8 read beats. Code 2 selects a 32-bit bus and 4 read beats.
- R6: Read beat k (counting from 0) drives `rom_addr` = block base + k × bus bytes (2 or 4), wrapping inside the 16-byte block.
- R7: `rom_cs_n` is low, and for reads `rom_rd_n` is also low, without a break from the setup cycle through the last data beat. Both go high in the cycle after the last beat.
- R8: `rsp_valid` is high for exactly one cycle, in the cycle after the last beat, with `rsp_err` low.
  - `req_size` codes are 0 = byte, 1 = halfword, 2 = word.
  - 32-bit bus: `rsp_rdata` is the beat at index addr[3:2].
  - 16-bit bus: bits 15:0 come from the beat at index addr[3:1] (for a word, {addr[3:2],0}). Bits 31:16 come from the next beat for a word and are zero otherwise.
- R9: A write is one access: the setup cycle, the first-beat waits (stretched by `rom_wait`), then one data cycle.
  - `rom_we_n` is low in the wait cycles and the data cycle.
  - `rom_rd_n` stays high throughout.
  - In the data cycle `rom_dq_oe` is high, `rom_dq_out` equals the write data and `rom_addr` equals the request address.
  - `rsp_valid` pulses in the cycle after the data cycle.
- R10: A request with `cfg_width` code 0 or 3 runs no bus cycle (`rom_cs_n` stays high). It is answered with `rsp_valid` and `rsp_err` high in the cycle after acceptance.
- R11: After reset `rom_cs_n`, `rom_rd_n`, `rom_we_n` and `rom_bs_n` are high, `req_ready` is high and `rsp_valid` is low. `req_ready` is low from the cycle after acceptance until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data |
| cfg_width | input | 2 | Bus width code: 1 = 16-bit, 2 = 32-bit, others rejected |
| cfg_first_wait | input | FW_W | Wait cycles before the first beat |
| cfg_beat_wait | input | BWT_W | Wait cycles before each later beat |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Assembled read data |
| rsp_err | output | 1 | Request rejected (unsupported width) |
| rom_addr | output | ADDR_W | External byte address |
| rom_cs_n | output | 1 | Chip select, active low |
| rom_rd_n | output | 1 | Read strobe, active low |
| rom_we_n | output | 1 | Write strobe, active low |
| rom_bs_n | output | 1 | Bus-start strobe, active low |
| rom_wait | input | 1 | Device wait request, active high |
| rom_dq_in | input | 32 | Data from the device |
| rom_dq_out | output | 32 | Data to the device |
| rom_dq_oe | output | 1 | Data output enable |

## Verification
The assertions assume a host that holds its request steady while `req_valid` waits for `req_ready`. They also assume a device that eventually drops `rom_wait`, so that each transfer reaches its end state. Data assembly is only defined for naturally aligned requests, meaning halfwords on even addresses and words on multiples of four. The stimulus therefore issues only aligned addresses and holds `rom_wait` high for a bounded number of cycles at the start of each transfer. It toggles `rom_wait` freely during later beats, where it must have no effect. The stimulus keeps `cfg_width` to codes 1 and 2, except in the directed rejection tests.

// File: rtl/brom_pkg.sv
package brom_pkg;
  localparam int DATA_W      = 32;
  localparam int BLOCK_BYTES = 16;
  localparam int OFF_W       = $clog2(BLOCK_BYTES);
  localparam int BURST16     = BLOCK_BYTES / 2;
  localparam int BURST32     = BLOCK_BYTES / 4;
  localparam int BEAT_W      = $clog2(BURST16);

  typedef enum logic [1:0] {
    WID_8   = 2'd0,
    WID_16  = 2'd1,
    WID_32  = 2'd2,
    WID_RSV = 2'd3
  } width_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_FWAIT,
    S_DATA,
    S_BWAIT,
    S_END,
    S_REJ
  } st_e;
endpackage

// File: rtl/brom_fsm.sv
module brom_fsm
  import brom_pkg::*;
#(
  parameter int FW_W  = 4,
  parameter int BWT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        width_code,
  input  logic [FW_W-1:0]   cfg_first,
  input  logic [BWT_W-1:0]  cfg_beat,
  input  logic              rom_wait,
  output st_e               state,
  output logic [BEAT_W-1:0] beat,
  output logic              accept,
  output logic              mode32,
  output logic              wr
);
  logic [FW_W-1:0]  cnt;
  logic [FW_W-1:0]  fw_q;
  logic [BWT_W-1:0] bw_q;
  logic             supported;
  logic             last_beat;

  assign accept    = (state == S_IDLE) && req_valid;
  assign supported = (width_code == WID_16) || (width_code == WID_32);
  assign last_beat = wr || (mode32 ? (beat == BEAT_W'(BURST32 - 1))
                                   : (beat == BEAT_W'(BURST16 - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      beat   <= '0;
      mode32 <= 1'b0;
      wr     <= 1'b0;
      fw_q   <= '0;
      bw_q   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            if (supported) begin
              state  <= S_SETUP;
              mode32 <= (width_code == WID_32);
              wr     <= req_write;
              fw_q   <= cfg_first;
              bw_q   <= cfg_beat;
              beat   <= '0;
            end else begin
              state <= S_REJ;
            end
          end
        end
        S_SETUP: begin
          cnt <= fw_q;
          if ((fw_q != '0) || rom_wait) state <= S_FWAIT;
          else                          state <= S_DATA;
        end
        S_FWAIT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          if ((cnt <= FW_W'(1)) && !rom_wait) state <= S_DATA;
        end
        S_DATA: begin
          if (last_beat) begin
            state <= S_END;
          end else begin
            beat <= beat + 1'b1;
            if (bw_q != '0) begin
              state <= S_BWAIT;
              cnt   <= FW_W'(bw_q);
            end
          end
        end
        S_BWAIT: begin
          cnt <= cnt - 1'b1;
          if (cnt == FW_W'(1)) state <= S_DATA;
        end
        S_END:   state <= S_IDLE;
        S_REJ:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  beat_wait_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BWAIT && cnt == FW_W'(1)) |=> (state == S_DATA));

  // R5
  beat_bound32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA && mode32 && !wr) |-> (beat <= BEAT_W'(BURST32 - 1)));

  // R2
  first_wait_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FWAIT && cnt > FW_W'(1)) |=> (state == S_FWAIT));
endmodule

// File: rtl/brom_agen.sv
module brom_agen
  import brom_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              mode32,
  input  logic              wr,
  input  logic [BEAT_W-1:0] beat,
  output logic [ADDR_W-1:0] rom_addr
);
  logic [ADDR_W-1:0] addr_q;
  logic [OFF_W-1:0]  beat_off;
  logic [ADDR_W-1:0] base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  // Offset truncated to the block width so the sequence wraps in the block.
  assign beat_off = mode32 ? OFF_W'({beat, 2'b00}) : OFF_W'({beat, 1'b0});
  assign base     = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign rom_addr = wr ? addr_q : (base | ADDR_W'(beat_off));
endmodule

// File: rtl/brom_gather.sv
module brom_gather
  import brom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_size,
  input  logic [1:0]        width_code,
  input  logic              sample,
  input  logic              mode32,
  input  logic [BEAT_W-1:0] beat,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rdata
);
  localparam int HALF = DATA_W / 2;

  logic [BEAT_W-1:0] idx0;
  logic              word16;
  logic [BEAT_W-1:0] idx_new;

  always_comb begin
    if (width_code == WID_32)  idx_new = BEAT_W'(req_off[OFF_W-1:2]);
    else if (req_size == 2'd2) idx_new = BEAT_W'({req_off[OFF_W-1:2], 1'b0});
    else                       idx_new = BEAT_W'(req_off[OFF_W-1:1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx0   <= '0;
      word16 <= 1'b0;
      rdata  <= '0;
    end else if (accept) begin
      idx0   <= idx_new;
      word16 <= (width_code != WID_32) && (req_size == 2'd2);
      rdata  <= '0;
    end else if (sample) begin
      if (mode32) begin
        if (beat == idx0) rdata <= dq_in;
      end else begin
        if (beat == idx0)                           rdata[HALF-1:0]      <= dq_in[HALF-1:0];
        if (word16 && (beat == BEAT_W'(idx0 + 1'b1))) rdata[DATA_W-1:HALF] <= dq_in[HALF-1:0];
      end
    end
  end
endmodule

// File: rtl/brom_ctrl.sv
module brom_ctrl
  import brom_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int FW_W   = 4,
  parameter int BWT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic [1:0]        cfg_width,
  input  logic [FW_W-1:0]   cfg_first_wait,
  input  logic [BWT_W-1:0]  cfg_beat_wait,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_cs_n,
  output logic              rom_rd_n,
  output logic              rom_we_n,
  output logic              rom_bs_n,
  input  logic              rom_wait,
  input  logic [31:0]       rom_dq_in,
  output logic [31:0]       rom_dq_out,
  output logic              rom_dq_oe
);
  st_e               state;
  logic [BEAT_W-1:0] beat;
  logic              accept;
  logic              mode32;
  logic              wr;
  logic              busy;
  logic [31:0]       wdata_q;

  brom_fsm #(.FW_W(FW_W), .BWT_W(BWT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .width_code (cfg_width),
    .cfg_first  (cfg_first_wait),
    .cfg_beat   (cfg_beat_wait),
    .rom_wait   (rom_wait),
    .state      (state),
    .beat       (beat),
    .accept     (accept),
    .mode32     (mode32),
    .wr         (wr)
  );

  brom_agen #(.ADDR_W(ADDR_W)) u_agen (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .req_addr (req_addr),
    .mode32   (mode32),
    .wr       (wr),
    .beat     (beat),
    .rom_addr (rom_addr)
  );

  brom_gather u_gather (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_off    (req_addr[OFF_W-1:0]),
    .req_size   (req_size),
    .width_code (cfg_width),
    .sample     ((state == S_DATA) && !wr),
    .mode32     (mode32),
    .beat       (beat),
    .dq_in      (rom_dq_in),
    .rdata      (rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wdata_q <= '0;
    else if (accept) wdata_q <= req_wdata;
  end

  assign busy       = (state == S_SETUP) || (state == S_FWAIT) ||
                      (state == S_DATA)  || (state == S_BWAIT);
  assign req_ready  = (state == S_IDLE);
  assign rom_cs_n   = !busy;
  assign rom_rd_n   = !(busy && !wr);
  assign rom_we_n   = !(wr && ((state == S_FWAIT) || (state == S_DATA)));
  assign rom_bs_n   = (state != S_SETUP);
  assign rom_dq_oe  = wr && busy;
  assign rom_dq_out = wdata_q;
  assign rsp_valid  = (state == S_END) || (state == S_REJ);
  assign rsp_err    = (state == S_REJ);

  // R4
  bs_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_bs_n |-> $past(req_valid && req_ready));

  // R4
  bs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_bs_n |=> rom_bs_n);

  // R7
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_cs_n) |-> rsp_valid);

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10
  reject_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> ($past(req_valid && req_ready) && rom_cs_n));

  // R11
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/sim_brom_ctrl.sv
module sim_brom_ctrl;
  localparam int ADDR_W = 26;

  typedef struct packed {
    logic [1:0] wd;
    logic [1:0] sz;
    logic [3:0] off;
    logic [3:0] fw;
    logic [1:0] bw;
    logic [2:0] xw;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{wd:2'd1, sz:2'd2, off:4'h0, fw:4'd2,  bw:2'd1, xw:3'd0},
    '{wd:2'd2, sz:2'd2, off:4'h8, fw:4'd0,  bw:2'd0, xw:3'd0},
    '{wd:2'd1, sz:2'd1, off:4'h6, fw:4'd15, bw:2'd3, xw:3'd0},
    '{wd:2'd2, sz:2'd0, off:4'hD, fw:4'd3,  bw:2'd2, xw:3'd2},
    '{wd:2'd1, sz:2'd2, off:4'hC, fw:4'd0,  bw:2'd2, xw:3'd3},
    '{wd:2'd1, sz:2'd0, off:4'h3, fw:4'd1,  bw:2'd0, xw:3'd0},
    '{wd:2'd2, sz:2'd2, off:4'h0, fw:4'd5,  bw:2'd3, xw:3'd1},
    '{wd:2'd1, sz:2'd2, off:4'h4, fw:4'd4,  bw:2'd1, xw:3'd0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_write = 1'b0;
  logic [1:0]        req_size = '0;
  logic [31:0]       req_wdata = '0;
  logic [1:0]        cfg_width = 2'd1;
  logic [3:0]        cfg_first_wait = '0;
  logic [1:0]        cfg_beat_wait = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic              rsp_err;
  logic [ADDR_W-1:0] rom_addr;
  logic              rom_cs_n, rom_rd_n, rom_we_n, rom_bs_n;
  logic              rom_wait = 1'b0;
  logic [31:0]       rom_dq_in;
  logic [31:0]       rom_dq_out;
  logic              rom_dq_oe;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] rom_f(input logic [ADDR_W-1:0] a);
    return {a[15:0] ^ 16'h3C5A, a[15:0] ^ 16'h00F1};
  endfunction

  assign rom_dq_in = rom_f(rom_addr);

  brom_ctrl #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
    .req_wdata(req_wdata), .cfg_width(cfg_width),
    .cfg_first_wait(cfg_first_wait), .cfg_beat_wait(cfg_beat_wait),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .rom_addr(rom_addr), .rom_cs_n(rom_cs_n), .rom_rd_n(rom_rd_n),
    .rom_we_n(rom_we_n), .rom_bs_n(rom_bs_n), .rom_wait(rom_wait),
    .rom_dq_in(rom_dq_in), .rom_dq_out(rom_dq_out), .rom_dq_oe(rom_dq_oe)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata(input logic [1:0] wd, input logic [1:0] sz,
                                            input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] base;
    logic [2:0]        idx;
    logic [15:0]       lo, hi;
    base = {a[ADDR_W-1:4], 4'h0};
    if (wd == 2'd2) return rom_f(base + ADDR_W'({a[3:2], 2'b00}));
    idx = (sz == 2'd2) ? {a[3:2], 1'b0} : a[3:1];
    lo  = rom_f(base + ADDR_W'({idx, 1'b0}))[15:0];
    hi  = (sz == 2'd2) ? rom_f(base + ADDR_W'({3'(idx + 3'd1), 1'b0}))[15:0] : 16'h0;
    return {hi, lo};
  endfunction

  task automatic issue(input logic [1:0] wd, input logic [1:0] sz, input logic [ADDR_W-1:0] a,
                       input logic [3:0] fw, input logic [1:0] bw, input logic wrt,
                       input logic [31:0] wd_data);
    @(negedge clk);
    cfg_width = wd; req_size = sz; req_addr = a; cfg_first_wait = fw;
    cfg_beat_wait = bw; req_write = wrt; req_wdata = wd_data; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_read(input int id, input vec_t v);
    logic [ADDR_W-1:0] a, base;
    int nb, step, first, total, cs_bad, rd_bad, bs_bad, addr_bad, rsp_cnt, rsp_at;
    logic [31:0] got;
    logic got_err, setup_addr_ok, ready_low;
    a     = ADDR_W'(26'h0120000 + id * 26'h100) | ADDR_W'(v.off);
    base  = {a[ADDR_W-1:4], 4'h0};
    nb    = (v.wd == 2'd2) ? 4 : 8;
    step  = (v.wd == 2'd2) ? 4 : 2;
    first = 1 + int'(v.fw) + int'(v.xw);
    total = first + (nb - 1) * (1 + int'(v.bw)) + 1;
    cs_bad = 0; rd_bad = 0; bs_bad = 0; addr_bad = 0; rsp_cnt = 0; rsp_at = -1;
    got = '0; got_err = 1'b1; setup_addr_ok = 1'b0; ready_low = 1'b0;
    issue(v.wd, v.sz, a, v.fw, v.bw, 1'b0, 32'h0);
    for (int cyc = 0; cyc <= total + 2; cyc++) begin
      if (cyc <= first) rom_wait = (cyc < int'(v.fw) + int'(v.xw));
      else              rom_wait = cyc[0];
      #1;
      if (cyc == 0) begin
        setup_addr_ok = (rom_addr == base);
        ready_low     = !req_ready;
      end
      if (rom_cs_n != (cyc >= total)) cs_bad++;
      if (rom_rd_n != (cyc >= total)) rd_bad++;
      if (rom_bs_n != (cyc != 0))     bs_bad++;
      if (cyc >= first && cyc < total && ((cyc - first) % (1 + int'(v.bw))) == 0) begin
        if (rom_addr != base + ADDR_W'(((cyc - first) / (1 + int'(v.bw))) * step)) addr_bad++;
      end
      if (rsp_valid) begin
        rsp_cnt++;
        if (rsp_at < 0) begin rsp_at = cyc; got = rsp_rdata; got_err = rsp_err; end
      end
      @(negedge clk);
    end
    rom_wait = 1'b0;
    chk($sformatf("R1 vec%0d setup address", id), 64'(setup_addr_ok), 64'd1);
    chk($sformatf("R11 vec%0d ready low while busy", id), 64'(ready_low), 64'd1);
    chk($sformatf("R4 vec%0d bus-start only in setup", id), 64'(bs_bad), 64'd0);
    chk($sformatf("R7 vec%0d cs/rd span", id), 64'(cs_bad + rd_bad), 64'd0);
    chk($sformatf("R6 vec%0d beat addresses", id), 64'(addr_bad), 64'd0);
    chk($sformatf("R2 R3 R5 vec%0d response cycle", id), 64'(rsp_at), 64'(total));
    chk($sformatf("R8 vec%0d single pulse", id), 64'(rsp_cnt), 64'd1);
    chk($sformatf("R8 vec%0d read data", id), {31'd0, got_err, got}, {32'd0, exp_rdata(v.wd, v.sz, a)});
  endtask

  task automatic run_reject(input logic [1:0] wd);
    int cs_low;
    cs_low = 0;
    issue(wd, 2'd2, 26'h0200040, 4'd3, 2'd1, 1'b0, 32'h0);
    #1;
    chk($sformatf("R10 width %0d error response", wd), {62'd0, rsp_valid, rsp_err}, 64'd3);
    for (int cyc = 0; cyc < 4; cyc++) begin
      if (!rom_cs_n || !rom_bs_n) cs_low++;
      @(negedge clk); #1;
    end
    chk($sformatf("R10 width %0d no bus cycle", wd), 64'(cs_low), 64'd0);
    chk($sformatf("R11 width %0d ready back", wd), {62'd0, req_ready, rsp_valid}, 64'd2);
  endtask

  task automatic run_write();
    int cs_cnt, rd_cnt, we_cnt, rsp_at;
    logic data_ok, addr_ok;
    cs_cnt = 0; rd_cnt = 0; we_cnt = 0; rsp_at = -1; data_ok = 1'b0; addr_ok = 1'b0;
    issue(2'd1, 2'd2, 26'h0155552, 4'd2, 2'd3, 1'b1, 32'hCAFE1234);
    for (int cyc = 0; cyc < 9; cyc++) begin
      rom_wait = (cyc < 3);
      #1;
      if (!rom_cs_n) cs_cnt++;
      if (!rom_rd_n) rd_cnt++;
      if (!rom_we_n) we_cnt++;
      if (cyc == 4) begin
        data_ok = rom_dq_oe && (rom_dq_out == 32'hCAFE1234);
        addr_ok = (rom_addr == 26'h0155552);
      end
      if (rsp_valid && rsp_at < 0) rsp_at = cyc;
      @(negedge clk);
    end
    rom_wait = 1'b0;
    chk("R9 write cs cycles", 64'(cs_cnt), 64'd5);
    chk("R9 write no read strobe", 64'(rd_cnt), 64'd0);
    chk("R9 write strobe cycles", 64'(we_cnt), 64'd4);
    chk("R9 write data and address", {62'd0, data_ok, addr_ok}, 64'd3);
    chk("R9 write response cycle", 64'(rsp_at), 64'd5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R11 reset state
    chk("R11 reset outputs",
        {58'd0, rom_cs_n, rom_rd_n, rom_we_n, rom_bs_n, req_ready, rsp_valid},
        {58'd0, 6'b111110});
    for (int i = 0; i < NVEC; i++) run_read(i, VECS[i]);
    run_reject(2'd0);
    run_reject(2'd3);
    run_write();
    // back-to-back read after a write still uses full burst timing (R5)
    run_read(9, '{wd:2'd2, sz:2'd1, off:4'h6, fw:4'd1, bw:2'd1, xw:3'd0});
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule